// File: doc/BRIEF.md
# Single-Pin Tearing Sync Decoder and Transfer Gate

This block sits between a display panel's tearing-effect output and the engine that pushes pixels to the panel. The panel drives one pin. That pin carries both its line-rate and its frame-rate sync pulses. The block measures how long each pulse stays at its active level. The width alone decides whether the pulse is a vertical sync, a horizontal sync or noise. The block then counts horizontal syncs from the last vertical sync. It holds back a transfer request until the raster reaches a safe point, then emits a one-cycle trigger.

Four gating modes exist, selected by a 2-bit code:
- Internal: requests pass straight through.
- Vertical-only: the trigger comes at the end of a vertical pulse.
- Line-locked (two codes): the trigger comes when the line count reaches a programmed value.

Pulse widths are counted in clock cycles after a synchronizer. Configuration arrives on static ports. A combinational error flag reports settings that cannot be decoded unambiguously.

Top module: `te_sync_decoder`

## Requirements
- R1: After reset, `trig_o` is 0 and no request is pending. With `trig_mode_i` = 00 at reset, `cfg_err_o` is 0.
- R2: In internal mode (`trig_mode_i` = 00), a high `start_req_i` sampled at a clock edge drives `trig_o` high for the cycle after that edge. A request left pending from a sync mode fires on the first edge at which the mode reads 00.
- R3: With `trig_mode_i` nonzero, `cfg_err_o` is 1 in any of these cases:
  - the horizontal width is below 2;
  - the vertical width is below 4 for code 01;
  - the vertical width is below 2 for codes 10 and 11;
  - the two widths are equal.
  While `cfg_err_o` is 1, no pulse is classified. A pending request then stays pending without firing.
- R4: Let W be the number of clock edges a pulse is sampled at its active level. The pulse is vertical when W ≥ vertical width. Otherwise it is horizontal when W ≥ horizontal width.
- R5: In mode 01, a pending request fires at the end of a vertical pulse and horizontal pulses never fire it. `trig_o` is high after the third rising edge following the last edge that sees the pin active. This latency holds with 2 synchronizer stages.
- R6: In modes 10 and 11, a vertical pulse clears the line count and each horizontal pulse adds one. A pending request fires with the R5 latency on the sync that makes the count equal `line_target_i`. A target of 0 fires on the vertical pulse.
- R7: A pulse shorter than both programmed widths leaves the line count and any pending request unchanged.
- R8: Without a request there is no trigger. Several requests before a firing sync yield exactly one trigger, which clears the pending state.
- R9: A polarity input of 1 makes its pulse active-high and 0 makes it active-low. With both inputs at 0, an active-low pin decodes exactly like an active-high one.
- R10: The line count saturates at 2047. Target 2047 is reached after 2047 horizontal pulses. A horizontal pulse arriving at the saturated count fires no request.
- R11: Width measurement saturates at 63 cycles, so a longer pulse measures 63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| te_pin_i | input | 1 | Raw tearing-effect pin from the panel |
| trig_mode_i | input | 2 | 00 internal, 01 vertical-only, 10/11 line-locked |
| vs_pol_i | input | 1 | Vertical pulse active level (1 = high) |
| hs_pol_i | input | 1 | Horizontal pulse active level (1 = high) |
| vs_width_i | input | 6 | Minimum vertical pulse width in cycles |
| hs_width_i | input | 6 | Minimum horizontal pulse width in cycles |
| line_target_i | input | 11 | Line count at which a line-locked request fires |
| start_req_i | input | 1 | Request to start a frame transfer |
| trig_o | output | 1 | One-cycle transfer trigger |
| cfg_err_o | output | 1 | Configuration cannot be decoded |

## Verification
Some properties are checked on every cycle:
- a vertical event clears the line count;
- a horizontal event advances the count by one, or holds it once saturated;
- the count never moves without an event;
- every trigger traces back to a pending or fresh request and leaves nothing pending;
- an error flag in a sync mode suppresses all classification.

The exact trigger latency, the width thresholds, the interplay of short noise pulses with line targets, inverted polarity, width saturation and the 2047-line limit can only be shown by the bench's pulse trains. The bench compares these against classification and line counts it computes itself.

// File: rtl/te_sync_pkg.sv
package te_sync_pkg;

    typedef enum logic [1:0] {
        TRIG_INTERNAL = 2'b00,
        TRIG_VSYNC    = 2'b01,
        TRIG_LINE     = 2'b10,
        TRIG_LINE_ALT = 2'b11
    } trig_mode_e;

    // Vertical-only mode needs a wider vertical pulse than line-locked mode.
    function automatic int unsigned min_vs_ticks(trig_mode_e m);
        return (m == TRIG_VSYNC) ? 4 : 2;
    endfunction

    function automatic logic is_line_mode(trig_mode_e m);
        return (m == TRIG_LINE) || (m == TRIG_LINE_ALT);
    endfunction

    localparam int unsigned MIN_HS_TICKS = 2;

endpackage

// File: rtl/te_pulse_meter.sv
module te_pulse_meter #(
    parameter int unsigned CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active_i,
    output logic          end_o,
    output logic [CW-1:0] width_o
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    typedef struct packed {
        logic [CW-1:0] cnt;
    } meter_t;

    meter_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (active_i) begin
            if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign end_o   = !active_i && (st_q.cnt != '0);
    assign width_o = st_q.cnt;

    // R11: a long pulse stays pinned at the top of the range
    p_width_sat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && st_q.cnt == CNT_MAX) |=> (st_q.cnt == CNT_MAX));

    // R4: after a pulse ends, measurement restarts from zero
    p_width_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        end_o |=> (st_q.cnt <= CW'(1)));

endmodule

// File: rtl/te_pulse_classifier.sv
module te_pulse_classifier #(
    parameter int unsigned CW   = 6,
    parameter int unsigned SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          te_i,
    input  logic          vs_pol_i,
    input  logic          hs_pol_i,
    input  logic [CW-1:0] vs_width_i,
    input  logic [CW-1:0] hs_width_i,
    input  logic          enable_i,
    output logic          vs_evt_o,
    output logic          hs_evt_o
);
    localparam int unsigned NCH  = 2;   // channel 0 vertical, 1 horizontal
    localparam int unsigned CH_V = 0;
    localparam int unsigned CH_H = 1;

    typedef struct packed {
        logic [SYNC-1:0] chain;
    } sync_t;

    sync_t sy_d, sy_q;
    logic  lvl;

    generate
        if (SYNC == 1) begin : g_sync_one
            always_comb begin
                sy_d       = sy_q;
                sy_d.chain = te_i;
            end
        end else begin : g_sync_many
            always_comb begin
                sy_d       = sy_q;
                sy_d.chain = {sy_q.chain[SYNC-2:0], te_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '0;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign lvl = sy_q.chain[SYNC-1];

    logic [NCH-1:0] pol_w;
    logic [NCH-1:0] act_w;
    logic [NCH-1:0] end_w;
    logic [CW-1:0]  width_w [NCH];

    assign pol_w[CH_V] = vs_pol_i;
    assign pol_w[CH_H] = hs_pol_i;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign act_w[g] = (lvl == pol_w[g]);
        te_pulse_meter #(.CW(CW)) u_meter (
            .clk      (clk),
            .rst_n    (rst_n),
            .active_i (act_w[g]),
            .end_o    (end_w[g]),
            .width_o  (width_w[g])
        );
    end

    logic vs_raw, hs_raw;

    always_comb begin
        vs_raw = end_w[CH_V] && (width_w[CH_V] >= vs_width_i);
        // vertical classification wins when both channels end together
        hs_raw = end_w[CH_H] && (width_w[CH_H] >= hs_width_i) && !vs_raw;
    end

    assign vs_evt_o = enable_i && vs_raw;
    assign hs_evt_o = enable_i && hs_raw;

    // R4: a pulse never counts as both kinds of sync
    p_kind_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(vs_evt_o && hs_evt_o));

endmodule

// File: rtl/te_cfg_check.sv
module te_cfg_check
    import te_sync_pkg::*;
#(
    parameter int unsigned CW = 6
) (
    input  trig_mode_e    mode_i,
    input  logic [CW-1:0] vs_width_i,
    input  logic [CW-1:0] hs_width_i,
    output logic          err_o
);
    logic hs_short, vs_short, same_width;

    always_comb begin
        hs_short   = hs_width_i < CW'(MIN_HS_TICKS);
        vs_short   = vs_width_i < CW'(min_vs_ticks(mode_i));
        same_width = vs_width_i == hs_width_i;
        err_o      = (mode_i != TRIG_INTERNAL) && (hs_short || vs_short || same_width);
    end

endmodule

// File: rtl/te_line_gate.sv
module te_line_gate
    import te_sync_pkg::*;
#(
    parameter int unsigned LW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  trig_mode_e    mode_i,
    input  logic [LW-1:0] line_target_i,
    input  logic          start_req_i,
    input  logic          vs_evt_i,
    input  logic          hs_evt_i,
    output logic          trig_o
);
    localparam logic [LW-1:0] LINE_MAX = {LW{1'b1}};

    typedef struct packed {
        logic [LW-1:0] line;
        logic          armed;
        logic          trig;
    } gate_t;

    gate_t st_d, st_q;
    logic  hit, pend, can_step;

    always_comb begin
        st_d      = st_q;
        st_d.trig = 1'b0;
        can_step  = hs_evt_i && !vs_evt_i && (st_q.line != LINE_MAX);

        if (vs_evt_i) begin
            st_d.line = '0;
        end else if (can_step) begin
            st_d.line = st_q.line + LW'(1);
        end

        hit = 1'b0;
        if (mode_i == TRIG_VSYNC) begin
            hit = vs_evt_i;
        end else if (is_line_mode(mode_i)) begin
            hit = (vs_evt_i && (line_target_i == '0)) ||
                  (can_step && (st_q.line + LW'(1) == line_target_i));
        end

        pend = st_q.armed || start_req_i;
        if (mode_i == TRIG_INTERNAL) begin
            st_d.trig  = pend;
            st_d.armed = 1'b0;
        end else if (pend && hit) begin
            st_d.trig  = 1'b1;
            st_d.armed = 1'b0;
        end else begin
            st_d.armed = pend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trig_o = st_q.trig;

    p_line_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vs_evt_i |=> (st_q.line == '0));

    p_line_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_evt_i && !vs_evt_i && st_q.line != LINE_MAX) |=> (st_q.line == $past(st_q.line) + LW'(1)));

    p_line_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_evt_i && !vs_evt_i) |=> $stable(st_q.line));

    p_line_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.line == LINE_MAX && !vs_evt_i) |=> (st_q.line == LINE_MAX));

    p_trig_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.trig |-> $past(st_q.armed || start_req_i));

    p_trig_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.trig |-> !st_q.armed);

endmodule

// File: rtl/te_sync_decoder.sv
module te_sync_decoder
    import te_sync_pkg::*;
#(
    parameter int unsigned WIDTH_BITS  = 6,
    parameter int unsigned LINE_BITS   = 11,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  te_pin_i,
    input  logic [1:0]            trig_mode_i,
    input  logic                  vs_pol_i,
    input  logic                  hs_pol_i,
    input  logic [WIDTH_BITS-1:0] vs_width_i,
    input  logic [WIDTH_BITS-1:0] hs_width_i,
    input  logic [LINE_BITS-1:0]  line_target_i,
    input  logic                  start_req_i,
    output logic                  trig_o,
    output logic                  cfg_err_o
);
    trig_mode_e mode;
    logic       cfg_err;
    logic       vs_evt, hs_evt;

    assign mode = trig_mode_e'(trig_mode_i);

    te_cfg_check #(.CW(WIDTH_BITS)) u_cfg (
        .mode_i     (mode),
        .vs_width_i (vs_width_i),
        .hs_width_i (hs_width_i),
        .err_o      (cfg_err)
    );

    te_pulse_classifier #(.CW(WIDTH_BITS), .SYNC(SYNC_STAGES)) u_cls (
        .clk        (clk),
        .rst_n      (rst_n),
        .te_i       (te_pin_i),
        .vs_pol_i   (vs_pol_i),
        .hs_pol_i   (hs_pol_i),
        .vs_width_i (vs_width_i),
        .hs_width_i (hs_width_i),
        .enable_i   (!cfg_err),
        .vs_evt_o   (vs_evt),
        .hs_evt_o   (hs_evt)
    );

    te_line_gate #(.LW(LINE_BITS)) u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode),
        .line_target_i (line_target_i),
        .start_req_i   (start_req_i),
        .vs_evt_i      (vs_evt),
        .hs_evt_i      (hs_evt),
        .trig_o        (trig_o)
    );

    assign cfg_err_o = cfg_err;

    // R3: a bad configuration silences the classifier
    p_err_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!vs_evt && !hs_evt));

endmodule

// File: tb/te_sync_decoder_tb.sv
module te_sync_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        te = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        vs_pol = 1'b1, hs_pol = 1'b1;
    logic [5:0]  vs_w = 6'd8, hs_w = 6'd3;
    logic [10:0] line_t = '0;
    logic        start = 1'b0;
    logic        trig, cfg_err;

    int checks = 0, failures = 0;
    int cyc = 0, trig_cnt = 0, last_trig = -1, last_fall = 0;
    logic act_lvl = 1'b1;

    always #2 clk = ~clk;   // 250 MHz

    te_sync_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .te_pin_i(te), .trig_mode_i(mode),
        .vs_pol_i(vs_pol), .hs_pol_i(hs_pol), .vs_width_i(vs_w), .hs_width_i(hs_w),
        .line_target_i(line_t), .start_req_i(start), .trig_o(trig), .cfg_err_o(cfg_err)
    );

    always @(posedge clk) begin
        #1;
        cyc++;
        if (trig) begin
            trig_cnt++;
            last_trig = cyc;
        end
    end

    function automatic int cls(int w, int hsw, int vsw);
        int ws = (w > 63) ? 63 : w;
        if (ws >= vsw) return 2;
        if (ws >= hsw) return 1;
        return 0;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(int w);
        @(negedge clk) te = act_lvl;
        repeat (w) @(negedge clk);
        te = ~act_lvl;
        last_fall = cyc;
        tick(5);
    endtask

    task automatic request();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic expect_fire(int n0, string req);
        chk(trig_cnt == n0 + 1, req, trig_cnt - n0, 1);
        chk(last_trig == last_fall + 3, req, last_trig - last_fall, 3);
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n0, rc, s;
        s = $urandom(32'd2024);
        tick(3);
        // R1
        chk(trig == 1'b0, "R1", trig, 0);
        chk(cfg_err == 1'b0, "R1", cfg_err, 0);
        @(negedge clk) rst_n = 1'b1;
        tick(3);
        chk(trig_cnt == 0, "R1", trig_cnt, 0);

        // R2: internal trigger
        n0 = trig_cnt;
        @(negedge clk) begin start = 1'b1; rc = cyc; end
        @(negedge clk) start = 1'b0;
        tick(3);
        chk(trig_cnt == n0 + 1, "R2", trig_cnt - n0, 1);
        chk(last_trig == rc + 1, "R2", last_trig - rc, 1);

        // R3: configuration errors
        @(negedge clk) begin mode = 2'b10; hs_w = 6'd1; end
        #1 chk(cfg_err == 1'b1, "R3 hs<2", cfg_err, 1);
        @(negedge clk) begin hs_w = 6'd3; mode = 2'b01; vs_w = 6'd3; end
        #1 chk(cfg_err == 1'b1, "R3 vs<4 mode1", cfg_err, 1);
        @(negedge clk) mode = 2'b11;
        #1 chk(cfg_err == 1'b1, "R3 equal widths", cfg_err, 1);
        @(negedge clk) begin vs_w = 6'd2; hs_w = 6'd3; end
        #1 chk(cfg_err == 1'b0, "R3 vs=2 mode2 ok", cfg_err, 0);
        // error blocks classification, request survives
        @(negedge clk) begin mode = 2'b10; vs_w = 6'd3; line_t = '0; end
        n0 = trig_cnt;
        request();
        pulse(9);
        chk(trig_cnt == n0, "R3 blocked", trig_cnt - n0, 0);
        @(negedge clk) vs_w = 6'd8;
        pulse(9);
        expect_fire(n0, "R3 pending kept");

        // R5: vertical-only mode ignores horizontal pulses
        @(negedge clk) mode = 2'b01;
        n0 = trig_cnt;
        request();
        pulse(3); pulse(5);
        chk(trig_cnt == n0, "R5 hsync ignored", trig_cnt - n0, 0);
        pulse(8);
        expect_fire(n0, "R5");

        // R8: merged requests, none without request
        n0 = trig_cnt;
        request(); request();
        pulse(10);
        expect_fire(n0, "R8 merged");
        pulse(10);
        chk(trig_cnt == n0 + 1, "R8 no request", trig_cnt - n0, 1);

        // R6: line-locked mode, line 3 and line 0
        @(negedge clk) begin mode = 2'b10; line_t = 11'd3; end
        n0 = trig_cnt;
        request();
        pulse(9); pulse(3); pulse(4);
        chk(trig_cnt == n0, "R6 early", trig_cnt - n0, 0);
        pulse(3);
        expect_fire(n0, "R6 line3");
        @(negedge clk) line_t = '0;
        n0 = trig_cnt;
        request();
        pulse(3);
        chk(trig_cnt == n0, "R6 hs not line0", trig_cnt - n0, 0);
        pulse(8);
        expect_fire(n0, "R6 line0");

        // R7: short pulses do not count
        @(negedge clk) begin mode = 2'b11; line_t = 11'd2; end
        n0 = trig_cnt;
        request();
        pulse(8); pulse(1); pulse(2); pulse(3); pulse(2);
        chk(trig_cnt == n0, "R7 short ignored", trig_cnt - n0, 0);
        pulse(3);
        expect_fire(n0, "R7");

        // R2: pending request fires on switch to internal
        n0 = trig_cnt;
        @(negedge clk) line_t = 11'd5;
        request();
        tick(3);
        @(negedge clk) begin mode = 2'b00; rc = cyc; end
        tick(3);
        chk(trig_cnt == n0 + 1, "R2 switch", trig_cnt - n0, 1);
        chk(last_trig == rc + 1, "R2 switch", last_trig - rc, 1);

        // R9: active-low pin
        @(negedge clk) begin act_lvl = 1'b0; vs_pol = 1'b0; hs_pol = 1'b0; te = 1'b1; mode = 2'b10; line_t = 11'd1; end
        tick(6);
        n0 = trig_cnt;
        request();
        pulse(9);
        chk(trig_cnt == n0, "R9 vs only", trig_cnt - n0, 0);
        pulse(4);
        expect_fire(n0, "R9");
        @(negedge clk) begin act_lvl = 1'b1; vs_pol = 1'b1; hs_pol = 1'b1; te = 1'b0; end
        tick(6);

        // R11: width saturation
        @(negedge clk) begin mode = 2'b01; vs_w = 6'd63; end
        n0 = trig_cnt;
        request();
        pulse(62);
        chk(trig_cnt == n0, "R11 below", trig_cnt - n0, 0);
        pulse(70);
        expect_fire(n0, "R11");
        @(negedge clk) vs_w = 6'd8;

        // R4 + R6: random pulse trains against bench classification
        @(negedge clk) mode = 2'b10;
        for (int it = 0; it < 20; it++) begin
            int tgt, hc;
            bit done;
            tgt = $urandom_range(0, 5);
            @(negedge clk) line_t = 11'(tgt);
            n0 = trig_cnt;
            request();
            pulse($urandom_range(8, 20));
            hc = 0;
            done = (tgt == 0);
            while (!done) begin
                int w;
                w = $urandom_range(1, 7);
                pulse(w);
                if (cls(w, 3, 8) == 1) hc++;
                if (hc == tgt) done = 1;
                else if (trig_cnt != n0) done = 1;
            end
            expect_fire(n0, "R4/R6 random");
        end

        // R10: saturation at 2047
        @(negedge clk) line_t = 11'd2047;
        n0 = trig_cnt;
        request();
        pulse(8);
        for (int i = 0; i < 2047; i++) pulse(3);
        expect_fire(n0, "R10 line2047");
        n0 = trig_cnt;
        request();
        pulse(3);
        chk(trig_cnt == n0, "R10 saturated", trig_cnt - n0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule